// File: doc/BRIEF.md
# Paged Processor Control Port for a Channel Switch

This block terminates an asynchronous, non-multiplexed processor bus on a time-slot switch. The bus has six address lines, eight data lines, an active-low select, an active-high strobe, a read/write line and an active-low acknowledge. An 8-bit control register acts as a page register. It picks which internal store a memory access reaches, which of eight streams it reaches, and two global modes. With address bit 5 low, the control register is accessed. With address bit 5 high, the low five address bits pick one of 32 channels inside the selected page. Six address lines can therefore reach the data memory and both connection memory arrays.

The block does not hold the stores and does not hold the serial timing. It issues each memory access on a valid/ready request channel and takes read data back on a response strobe. Back-pressure works as follows: once `mem_req_valid` rises, the request fields stay frozen until a cycle in which `mem_req_ready` is high. The downstream side may hold ready low for any number of cycles. A write is complete at its handshake. A read is complete when `mem_rsp_valid` pulses, which may happen many cycles later because data-memory reads wait for the serial frame. The response channel has no ready: the block always has room for the one response it is waiting for. Control-register accesses never touch the request channel, so they acknowledge after only the input synchronizer delay.

Top module: `pcif_top`

## Requirements
- R1: After reset the control register reads 0x00, `bus_ack_n` is high, `bus_rdata_oe` is low, `mem_req_valid` is low and `cfg_msg_all` is low.
- R2: When address bit 5 is 0, the access reads or writes the control register whatever bits 4-0 hold. It issues no memory request, and it acknowledges within 5 clocks of the strobe becoming active.
- R3: When address bit 5 is 1, the memory request carries the stream from control bits 2-0 and the channel from address bits 4-0.
- R4: Control bits 4-3 select the target: 01 is data memory, 10 is connection low, 11 is connection high. `mem_req_sel` carries the same code, and writes carry the bus data.
- R5: When control bit 7 is 1, reads go to the data memory and writes go to connection low, for the selected stream, whatever bits 4-3 hold.
- R6: A read of connection high returns the response with bits 7-3 forced to 0.
- R7: A write with data memory selected and bit 7 clear is acknowledged, issues no request and leaves the data memory unchanged.
- R8: `bus_ack_n` stays low while the select and strobe remain active. It returns high within 5 clocks after either one is released, and `mem_req_valid` is never high while acknowledge is low.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and every request field hold their values in the next cycle.
- R10: A memory read acknowledges only after `mem_rsp_valid` has been seen, and it returns that response. `bus_rdata_oe` is high only during an acknowledged read.
- R11: `cfg_msg_all` follows control bit 6.
- R12: With control bits 4-3 at 00 and bit 7 clear, a memory-page read returns 0x00 and a write has no effect. Neither one issues a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_ds | input | 1 | Data strobe, active high, asynchronous |
| bus_rd_wr | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bus address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| bus_rdata_oe | output | 1 | Drive enable for read data |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_sel | output | 2 | Target store code (01 data, 10 conn low, 11 conn high) |
| mem_req_write | output | 1 | 1 = write request |
| mem_req_stream | output | 3 | Stream number |
| mem_req_chan | output | 5 | Channel number |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | One-cycle read response strobe |
| mem_rsp_data | input | 8 | Read response data |
| cfg_msg_all | output | 1 | Global message mode (control bit 6) |

## Verification
The hardest situation to reach is a memory read that is first held off by back-pressure and then answered many cycles later. At the same moment the processor must keep its strobe asserted and the control register must be re-paged between accesses. The bench's memory responder therefore stalls ready for a varying number of cycles on each request. It answers data-memory reads only after a long delay and returns junk in the unused upper bits of connection-high reads. Split mode is then checked by writing and reading the same channel under two different control settings.

// File: rtl/pcif_pkg.sv
package pcif_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 6;
  localparam int STREAM_W = 3;
  localparam int CHAN_W   = ADDR_W - 1;

  typedef enum logic [1:0] {
    SEL_RSVD  = 2'b00,
    SEL_DATA  = 2'b01,
    SEL_CLOW  = 2'b10,
    SEL_CHIGH = 2'b11
  } mem_sel_e;

  typedef struct packed {
    logic                split;
    logic                msg_all;
    logic                spare;
    mem_sel_e            sel;
    logic [STREAM_W-1:0] stream;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_ACK
  } bus_st_e;
endpackage

// File: rtl/pcif_sync.sv
module pcif_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= din;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcif_decode.sv
module pcif_decode
  import pcif_pkg::*;
(
  input  ctrl_t    ctrl,
  input  logic     page_hit,
  input  logic     is_read,
  output logic     is_reg,
  output logic     do_mem,
  output mem_sel_e target
);
  always_comb begin
    is_reg = !page_hit;
    do_mem = 1'b0;
    target = ctrl.sel;
    if (page_hit) begin
      if (ctrl.split) begin
        target = is_read ? SEL_DATA : SEL_CLOW;
        do_mem = 1'b1;
      end else begin
        unique case (ctrl.sel)
          SEL_RSVD:  do_mem = 1'b0;
          SEL_DATA:  do_mem = is_read;
          default:   do_mem = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcif_top.sv
module pcif_top
  import pcif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIGH_BITS   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_cs_n,
  input  logic                bus_ds,
  input  logic                bus_rd_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rdata_oe,
  output logic                bus_ack_n,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [1:0]          mem_req_sel,
  output logic                mem_req_write,
  output logic [STREAM_W-1:0] mem_req_stream,
  output logic [CHAN_W-1:0]   mem_req_chan,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                cfg_msg_all
);
  localparam logic [DATA_W-1:0] HIGH_MASK = DATA_W'((1 << HIGH_BITS) - 1);

  // strobe synchronizer: {cs_n, ds}
  logic [1:0] strb_s;
  pcif_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bus_cs_n, bus_ds}),
    .dout (strb_s)
  );
  logic cycle_on;
  assign cycle_on = !strb_s[1] && strb_s[0];

  ctrl_t    ctrl_q;
  bus_st_e  st_q;
  logic     rd_q;
  logic [DATA_W-1:0] rdata_q;
  mem_sel_e sel_q;
  logic     wr_q;
  logic [STREAM_W-1:0] stream_q;
  logic [CHAN_W-1:0]   chan_q;
  logic [DATA_W-1:0]   wdata_q;

  logic     dec_reg, dec_mem;
  mem_sel_e dec_tgt;
  pcif_decode u_dec (
    .ctrl    (ctrl_q),
    .page_hit(bus_addr[ADDR_W-1]),
    .is_read (bus_rd_wr),
    .is_reg  (dec_reg),
    .do_mem  (dec_mem),
    .target  (dec_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ctrl_q   <= '0;
      rd_q     <= 1'b0;
      rdata_q  <= '0;
      sel_q    <= SEL_RSVD;
      wr_q     <= 1'b0;
      stream_q <= '0;
      chan_q   <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cycle_on) begin
          rd_q <= bus_rd_wr;
          if (dec_reg) begin
            if (bus_rd_wr) rdata_q <= ctrl_q;
            else           ctrl_q  <= ctrl_t'(bus_wdata);
            st_q <= ST_ACK;
          end else if (dec_mem) begin
            sel_q    <= dec_tgt;
            wr_q     <= !bus_rd_wr;
            stream_q <= ctrl_q.stream;
            chan_q   <= bus_addr[CHAN_W-1:0];
            wdata_q  <= bus_wdata;
            st_q     <= ST_REQ;
          end else begin
            rdata_q <= '0;
            st_q    <= ST_ACK;
          end
        end
        ST_REQ: if (mem_req_ready) st_q <= wr_q ? ST_ACK : ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          rdata_q <= (sel_q == SEL_CHIGH) ? (mem_rsp_data & HIGH_MASK) : mem_rsp_data;
          st_q    <= ST_ACK;
        end
        ST_ACK: if (!cycle_on) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic [STREAM_W-1:0] page_stream;
  assign page_stream = ctrl_q.stream;

  assign bus_ack_n      = (st_q != ST_ACK);
  assign bus_rdata_oe   = (st_q == ST_ACK) && rd_q;
  assign bus_rdata      = rdata_q;
  assign mem_req_valid  = (st_q == ST_REQ);
  assign mem_req_sel    = sel_q;
  assign mem_req_write  = wr_q;
  assign mem_req_stream = stream_q;
  assign mem_req_chan   = chan_q;
  assign mem_req_wdata  = wdata_q;
  assign cfg_msg_all    = ctrl_q.msg_all;
endmodule

// File: rtl/pcif_chk.sv
module pcif_chk
  import pcif_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_ack_n,
  input logic                bus_rdata_oe,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic [1:0]          mem_req_sel,
  input logic                mem_req_write,
  input logic [STREAM_W-1:0] mem_req_stream,
  input logic [CHAN_W-1:0]   mem_req_chan,
  input logic [DATA_W-1:0]   mem_req_wdata,
  input logic [STREAM_W-1:0] page_stream
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid &&
      $stable({mem_req_sel, mem_req_write, mem_req_stream, mem_req_chan, mem_req_wdata}))); // R9
  AST_ACK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> !mem_req_valid); // R8
  AST_DM_RDONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_sel == 2'b01) |-> !mem_req_write); // R7
  AST_OE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> !bus_ack_n); // R10
  AST_REQ_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_stream == page_stream)); // R3
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_sel != 2'b00)); // R12
endmodule

bind pcif_top pcif_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_ack_n     (bus_ack_n),
  .bus_rdata_oe  (bus_rdata_oe),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_sel   (mem_req_sel),
  .mem_req_write (mem_req_write),
  .mem_req_stream(mem_req_stream),
  .mem_req_chan  (mem_req_chan),
  .mem_req_wdata (mem_req_wdata),
  .page_stream   (page_stream)
);

// File: tb/pcif_top_tb_top.sv
module pcif_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       bus_cs_n = 1'b1, bus_ds = 1'b0, bus_rd_wr = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       bus_rdata_oe, bus_ack_n;
  logic       mem_req_valid, mem_req_ready, mem_req_write;
  logic [1:0] mem_req_sel;
  logic [2:0] mem_req_stream;
  logic [4:0] mem_req_chan;
  logic [7:0] mem_req_wdata;
  logic       mem_rsp_valid;
  logic [7:0] mem_rsp_data;
  logic       cfg_msg_all;

  pcif_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ds(bus_ds), .bus_rd_wr(bus_rd_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .bus_ack_n(bus_ack_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_sel(mem_req_sel), .mem_req_write(mem_req_write), .mem_req_stream(mem_req_stream),
    .mem_req_chan(mem_req_chan), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cfg_msg_all(cfg_msg_all)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // scoreboard of expected memory requests: {sel, write, stream, chan, wdata}
  typedef struct packed {
    logic [1:0] sel; logic wr; logic [2:0] stream; logic [4:0] chan; logic [7:0] wdata;
  } req_t;
  req_t exp_q[$];

  task automatic expect_req(input logic [1:0] s, input logic w, input logic [2:0] st,
                            input logic [4:0] ch, input logic [7:0] wd);
    req_t r;
    r.sel = s; r.wr = w; r.stream = st; r.chan = ch; r.wdata = w ? wd : 8'h00;
    exp_q.push_back(r);
  endtask

  function automatic logic [7:0] dm_val(input logic [2:0] s, input logic [4:0] c);
    return {s, c} ^ 8'h5A;
  endfunction

  logic [7:0] cl_mem [256];
  logic [7:0] ch_mem [256];

  // memory responder and scoreboard monitor
  initial begin
    int stall_ctr = 0;
    for (int i = 0; i < 256; i++) begin cl_mem[i] = 8'h00; ch_mem[i] = 8'h00; end
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid) begin
        req_t got, exp;
        int idx, dly;
        repeat (stall_ctr % 3) @(negedge clk);
        stall_ctr++;
        mem_req_ready = 1'b1;
        got.sel = mem_req_sel; got.wr = mem_req_write; got.stream = mem_req_stream;
        got.chan = mem_req_chan; got.wdata = mem_req_write ? mem_req_wdata : 8'h00;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R2/R7/R12 unexpected request actual=0x%05h expected=none", got);
        end else begin
          exp = exp_q.pop_front();
          if (got !== exp) begin
            failures++;
            $display("FAIL R3/R4/R9 request actual=0x%05h expected=0x%05h", got, exp);
          end
        end
        idx = {got.stream, got.chan};
        if (got.wr) begin
          if (got.sel == 2'b10) cl_mem[idx] = got.wdata;
          if (got.sel == 2'b11) ch_mem[idx] = got.wdata & 8'h07;
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (!got.wr) begin
          dly = (got.sel == 2'b01) ? 24 : 3;
          repeat (dly - 1) @(negedge clk);
          mem_rsp_valid = 1'b1;
          case (got.sel)
            2'b01:   mem_rsp_data = dm_val(got.stream, got.chan);
            2'b10:   mem_rsp_data = cl_mem[idx];
            default: mem_rsp_data = {5'b10101, ch_mem[idx][2:0]};
          endcase
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  int last_cyc;
  int last_rel;
  bit last_held;

  task automatic bus_xfer(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                          input int hold, output logic [7:0] rdat);
    @(negedge clk);
    bus_addr = a; bus_rd_wr = rd; bus_wdata = wd; bus_cs_n = 1'b0; bus_ds = 1'b1;
    last_cyc = 0;
    while (bus_ack_n && last_cyc < 2000) begin @(negedge clk); last_cyc++; end
    rdat = bus_rdata;
    if (rd && !bus_rdata_oe) rdat = 8'hxx;
    last_held = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (bus_ack_n) last_held = 1'b0;
    end
    bus_ds = 1'b0; bus_cs_n = 1'b1;
    last_rel = 0;
    while (!bus_ack_n && last_rel < 50) begin @(negedge clk); last_rel++; end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    bus_xfer(1'b0, a, d, 0, dummy);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_xfer(1'b1, a, 8'h00, 0, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    // R1 reset state
    check8("R1 ack_n", {7'd0, bus_ack_n}, 8'h01);
    check8("R1 req_valid", {7'd0, mem_req_valid}, 8'h00);
    check8("R1 oe", {7'd0, bus_rdata_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'h00, d); check8("R1 ctrl after reset", d, 8'h00);
    check8("R1 msg_all", {7'd0, cfg_msg_all}, 8'h00);

    // R2 control register write/read at different low address bits, fast
    wr(6'h00, 8'h15);
    check8("R2 fast write ack", {7'd0, last_cyc <= 5}, 8'h01);
    rd(6'h1F, d); check8("R2 ctrl read alias", d, 8'h15);

    // R3/R4 connection low write and read, stream 5
    expect_req(2'b10, 1'b1, 3'd5, 5'd7, 8'hA3);
    wr(6'h27, 8'hA3);
    expect_req(2'b10, 1'b0, 3'd5, 5'd7, 8'h00);
    rd(6'h27, d); check8("R4 conn low readback", d, 8'hA3);

    // R6 connection high, stream 3, channel 31
    wr(6'h00, 8'h1B);
    expect_req(2'b11, 1'b1, 3'd3, 5'd31, 8'hFF);
    wr(6'h3F, 8'hFF);
    expect_req(2'b11, 1'b0, 3'd3, 5'd31, 8'h00);
    rd(6'h3F, d); check8("R6 conn high masked", d, 8'h07);

    // R10/R4 data memory read with long latency, stream 2 chan 4
    wr(6'h00, 8'h0A);
    expect_req(2'b01, 1'b0, 3'd2, 5'd4, 8'h00);
    rd(6'h24, d); check8("R4 data mem read", d, dm_val(3'd2, 5'd4));
    check8("R10 ack waits response", {7'd0, last_cyc >= 20}, 8'h01);

    // R7 data memory write ignored
    wr(6'h24, 8'hEE);
    check8("R7 write acked", {7'd0, last_cyc < 2000}, 8'h01);
    expect_req(2'b01, 1'b0, 3'd2, 5'd4, 8'h00);
    rd(6'h24, d); check8("R7 data mem unchanged", d, dm_val(3'd2, 5'd4));

    // R5 split mode, stream 6 chan 9
    wr(6'h00, 8'h8E);
    expect_req(2'b10, 1'b1, 3'd6, 5'd9, 8'h5C);
    wr(6'h29, 8'h5C);
    expect_req(2'b01, 1'b0, 3'd6, 5'd9, 8'h00);
    rd(6'h29, d); check8("R5 split read from data mem", d, dm_val(3'd6, 5'd9));
    wr(6'h00, 8'h16);
    expect_req(2'b10, 1'b0, 3'd6, 5'd9, 8'h00);
    rd(6'h29, d); check8("R5 split write reached conn low", d, 8'h5C);

    // R12 reserved select
    wr(6'h00, 8'h01);
    rd(6'h23, d); check8("R12 reserved read zero", d, 8'h00);
    wr(6'h23, 8'h77);

    // R11 global message mode
    wr(6'h00, 8'h40);
    check8("R11 msg_all set", {7'd0, cfg_msg_all}, 8'h01);
    rd(6'h11, d); check8("R11 ctrl readback", d, 8'h40);

    // R8 acknowledge held while strobe held, then released
    bus_xfer(1'b0, 6'h00, 8'h00, 12, d);
    check8("R8 ack held", {7'd0, last_held}, 8'h01);
    check8("R8 ack released", {7'd0, last_rel <= 5}, 8'h01);
    check8("R11 msg_all cleared", {7'd0, cfg_msg_all}, 8'h00);

    repeat (40) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R3 missing requests actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule